// File: doc/BRIEF.md
# Flash Sector Write-Protection Controller

This block holds the write-protection logic of a parallel NOR-style flash device. It sits between the host bus (active-low chip select, output enable and write enable, plus address and an 8-bit command byte) and the program/erase engine. Each bus strobe passes through a two-stage synchronizer and a glitch filter. A write is qualified against the bus inhibit rules, and the block keeps one protect bit per sector. Each program or erase command yields a one-cycle grant or a one-cycle reject for the engine.

The block also enforces a power-up strobe trap and a low-supply lockout. A high-voltage-reset input temporarily lifts protection. A protection-verify read returns the state of an addressed sector. The top address bits select the sector. Commands are latched while the write is qualified and act when the qualified write ends, which is the rising edge of write enable. Command bytes: 10h program, 30h erase, 60h protect sector, 40h unprotect sector. Other bytes are ignored.

Top module: `flash_prot_ctrl`

## Requirements
- R1: After rst_ni is released, every sector reads as unprotected, and pe_req_o, pe_reject_o and rd_data_o are zero.
- R2: A write is qualified only while filtered cs_ni=0, we_ni=0 and oe_ni=1. A cycle with oe_ni low or cs_ni high issues no command.
- R3: A strobe level that lasts fewer than FILT_LEN clock samples is filtered out and starts no write.
- R4: If a write is already qualified when reset or lockout ends, the end of that write is not taken as a command.
- R5: While vlow_i is high, no write is accepted, no grant or reject is issued, rd_data_o is zero and protect bits do not change. Writes are accepted again once vlow_i falls.
- R6: Command 60h sets the protect bit of the sector in address bits [ADDR_W-1 -: SECT_AW]. No other sector changes.
- R7: Command 40h first sets every protect bit. In the following cycle it clears only the addressed sector's bit.
- R8: Command 10h (program) or 30h (erase) on an unprotected sector gives a one-cycle pe_req_o. On a protected sector it gives a one-cycle pe_reject_o. Both report pe_sector_o, and pe_erase_o is 1 for erase and 0 for program. Grant and reject never occur together.
- R9: While hvrst_i is high, protected sectors are granted. When hvrst_i falls, those sectors reject again and keep their protect bits.
- R10: A read (cs_ni=0, oe_ni=0, we_ni=1) with address bit 6 = 0, bit 1 = 1 and bit 0 = 0 returns the protect bit of the addressed sector on rd_data_o bit 0 and bit 16, with all other bits 0. Any other read address returns 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Internal clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| cs_ni | input | 1 | Chip select, active low |
| oe_ni | input | 1 | Output enable, active low |
| we_ni | input | 1 | Write enable, active low |
| addr_i | input | ADDR_W | Bus address; top SECT_AW bits select the sector |
| data_i | input | 8 | Command byte |
| vlow_i | input | 1 | Supply below lockout threshold |
| hvrst_i | input | 1 | High voltage present on reset pin |
| pe_req_o | output | 1 | One-cycle program/erase grant |
| pe_reject_o | output | 1 | One-cycle program/erase reject |
| pe_erase_o | output | 1 | Request kind: 1 erase, 0 program |
| pe_sector_o | output | SECT_AW | Sector of the request |
| rd_data_o | output | 24 | Protection-verify read data |

## Verification
Each grant or reject becomes due 3+FILT_LEN clock edges after the raw write enable rises: two synchronizer stages, FILT_LEN filter samples, and one decode register. Verify-read data becomes due the same number of edges after the read strobes settle. The bench holds every bus phase for at least 12 cycles and counts pulses in that window with a monitor that samples 2 ns after each rising edge. It checks the count, sector and kind only after the window closes. Held-off writes (glitch, trap, lockout, inhibit) are checked by confirming that no pulse appears in the same window. Protect state is read back through verify reads against a bench model.

// File: rtl/flash_prot_pkg.sv
package flash_prot_pkg;
  typedef enum logic [7:0] {
    CMD_PROG   = 8'h10,
    CMD_ERASE  = 8'h30,
    CMD_UNPROT = 8'h40,
    CMD_PROT   = 8'h60
  } cmd_e;
endpackage

// File: rtl/flash_prot_sync.sv
module flash_prot_sync #(
  parameter int              W       = 1,
  parameter int              STAGES  = 2,
  parameter logic [W-1:0]    RST_VAL = '0
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  logic [STAGES-1:0][W-1:0] pipe_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) pipe_q <= {STAGES{RST_VAL}};
    else         pipe_q <= {pipe_q[STAGES-2:0], d_i};
  end

  assign q_o = pipe_q[STAGES-1];
endmodule

// File: rtl/flash_prot_deglitch.sv
module flash_prot_deglitch #(
  parameter int   LEN     = 4,
  parameter logic RST_VAL = 1'b1
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic d_i,
  output logic q_o
);
  localparam int CW = $clog2(LEN);

  logic [CW-1:0] cnt_q;

  // output follows input only after LEN consecutive differing samples
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      q_o   <= RST_VAL;
      cnt_q <= '0;
    end else if (d_i == q_o) begin
      cnt_q <= '0;
    end else if (cnt_q == CW'(LEN - 1)) begin
      q_o   <= d_i;
      cnt_q <= '0;
    end else begin
      cnt_q <= cnt_q + 1'b1;
    end
  end
endmodule

// File: rtl/flash_prot_core.sv
module flash_prot_core
  import flash_prot_pkg::*;
#(
  parameter int ADDR_W  = 12,
  parameter int SECT_AW = 3,
  parameter int SETTLE  = 10,
  localparam int NSECT  = 1 << SECT_AW,
  localparam int SCW    = $clog2(SETTLE + 1)
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               lock_i,
  input  logic               hv_i,
  input  logic               cs_n_i,
  input  logic               oe_n_i,
  input  logic               we_n_i,
  input  logic [ADDR_W-1:0]  addr_i,
  input  logic [7:0]         data_i,
  output logic               pe_req_o,
  output logic               pe_reject_o,
  output logic               pe_erase_o,
  output logic [SECT_AW-1:0] pe_sector_o,
  output logic [23:0]        rd_data_o,
  output logic [NSECT-1:0]   prot_o,
  output logic               trap_o,
  output logic               pend_o
);
  logic               wr_act, rd_act, wr_q, settled, end_wr, allow, vfy_hit;
  logic [SCW-1:0]     settle_q;
  logic [SECT_AW-1:0] cmd_sec_q, pend_sec_q, rd_sec;
  logic [7:0]         cmd_q;
  logic               unused_addr;

  assign unused_addr = ^addr_i;
  assign wr_act  = !cs_n_i && !we_n_i && oe_n_i;
  assign rd_act  = !cs_n_i && !oe_n_i && we_n_i;
  assign settled = (settle_q == SCW'(SETTLE));
  assign end_wr  = wr_q && !wr_act && settled && !trap_o;
  assign allow   = !prot_o[cmd_sec_q] || hv_i;
  assign rd_sec  = addr_i[ADDR_W-1 -: SECT_AW];
  assign vfy_hit = rd_act && !addr_i[6] && addr_i[1] && !addr_i[0];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      settle_q    <= '0;
      trap_o      <= 1'b1;
      wr_q        <= 1'b0;
      cmd_sec_q   <= '0;
      cmd_q       <= '0;
      prot_o      <= '0;
      pend_o      <= 1'b0;
      pend_sec_q  <= '0;
      pe_req_o    <= 1'b0;
      pe_reject_o <= 1'b0;
      pe_erase_o  <= 1'b0;
      pe_sector_o <= '0;
      rd_data_o   <= '0;
    end else if (lock_i) begin
      // supply lockout: command path held in reset, protect bits retained
      settle_q    <= '0;
      trap_o      <= 1'b1;
      wr_q        <= 1'b0;
      pend_o      <= 1'b0;
      pe_req_o    <= 1'b0;
      pe_reject_o <= 1'b0;
      rd_data_o   <= '0;
    end else begin
      pe_req_o    <= 1'b0;
      pe_reject_o <= 1'b0;
      wr_q        <= wr_act;
      if (wr_act) begin
        cmd_sec_q <= addr_i[ADDR_W-1 -: SECT_AW];
        cmd_q     <= data_i;
      end
      // power-up trap: a write already active at settle time is discarded
      if (!settled) begin
        settle_q <= settle_q + 1'b1;
        if (settle_q == SCW'(SETTLE - 1)) trap_o <= wr_act;
      end else if (trap_o && !wr_act) begin
        trap_o <= 1'b0;
      end
      if (pend_o) begin
        prot_o[pend_sec_q] <= 1'b0;
        pend_o             <= 1'b0;
      end
      if (end_wr) begin
        case (cmd_q)
          CMD_PROT: prot_o[cmd_sec_q] <= 1'b1;
          CMD_UNPROT: begin
            prot_o     <= '1;
            pend_o     <= 1'b1;
            pend_sec_q <= cmd_sec_q;
          end
          CMD_PROG, CMD_ERASE: begin
            pe_req_o    <= allow;
            pe_reject_o <= !allow;
            pe_erase_o  <= (cmd_q == CMD_ERASE);
            pe_sector_o <= cmd_sec_q;
          end
          default: ;
        endcase
      end
      rd_data_o <= vfy_hit ? {7'b0, prot_o[rd_sec], 8'h00, 7'b0, prot_o[rd_sec]} : 24'h0;
    end
  end
endmodule

// File: rtl/flash_prot_ctrl.sv
module flash_prot_ctrl #(
  parameter int ADDR_W      = 12,
  parameter int SECT_AW     = 3,
  parameter int SYNC_STAGES = 2,
  parameter int FILT_LEN    = 4,
  localparam int NSECT      = 1 << SECT_AW,
  localparam int SETTLE     = SYNC_STAGES + FILT_LEN + 4
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               cs_ni,
  input  logic               oe_ni,
  input  logic               we_ni,
  input  logic [ADDR_W-1:0]  addr_i,
  input  logic [7:0]         data_i,
  input  logic               vlow_i,
  input  logic               hvrst_i,
  output logic               pe_req_o,
  output logic               pe_reject_o,
  output logic               pe_erase_o,
  output logic [SECT_AW-1:0] pe_sector_o,
  output logic [23:0]        rd_data_o
);
  logic [4:0]       raw, synced;
  logic [2:0]       strb_f;
  logic             lock_s, hv_s, trap_flag, unp_pend;
  logic [NSECT-1:0] prot_vec;

  assign raw = {hvrst_i, vlow_i, oe_ni, we_ni, cs_ni};

  flash_prot_sync #(
    .W(5), .STAGES(SYNC_STAGES), .RST_VAL(5'b00111)
  ) u_sync (
    .clk_i(clk_i), .rst_ni(rst_ni), .d_i(raw), .q_o(synced)
  );

  assign lock_s = synced[3];
  assign hv_s   = synced[4];

  for (genvar g = 0; g < 3; g++) begin : g_filt
    flash_prot_deglitch #(.LEN(FILT_LEN), .RST_VAL(1'b1)) u_flt (
      .clk_i(clk_i), .rst_ni(rst_ni), .d_i(synced[g]), .q_o(strb_f[g])
    );
  end

  flash_prot_core #(
    .ADDR_W(ADDR_W), .SECT_AW(SECT_AW), .SETTLE(SETTLE)
  ) u_core (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .lock_i     (lock_s),
    .hv_i       (hv_s),
    .cs_n_i     (strb_f[0]),
    .oe_n_i     (strb_f[2]),
    .we_n_i     (strb_f[1]),
    .addr_i     (addr_i),
    .data_i     (data_i),
    .pe_req_o   (pe_req_o),
    .pe_reject_o(pe_reject_o),
    .pe_erase_o (pe_erase_o),
    .pe_sector_o(pe_sector_o),
    .rd_data_o  (rd_data_o),
    .prot_o     (prot_vec),
    .trap_o     (trap_flag),
    .pend_o     (unp_pend)
  );
endmodule

// File: rtl/flash_prot_chk.sv
module flash_prot_chk #(
  parameter int SECT_AW = 3,
  localparam int NSECT  = 1 << SECT_AW
) (
  input logic               clk_i,
  input logic               rst_ni,
  input logic               lock_i,
  input logic               hv_i,
  input logic               trap_i,
  input logic               pend_i,
  input logic [NSECT-1:0]   prot_i,
  input logic               pe_req_i,
  input logic               reject_i,
  input logic [SECT_AW-1:0] sector_i,
  input logic [23:0]        rd_data_i
);
  a_r8_grant_reject_exclusive: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(pe_req_i && reject_i));

  a_r8_grant_single_cycle: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pe_req_i |=> !pe_req_i);

  a_r9_grant_needs_unprot_or_hv: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pe_req_i |-> ($past(hv_i) || !prot_i[sector_i]));

  a_r8_reject_only_protected: assert property (@(posedge clk_i) disable iff (!rst_ni)
    reject_i |-> (prot_i[sector_i] && !$past(hv_i)));

  a_r5_lockout_quiet: assert property (@(posedge clk_i) disable iff (!rst_ni)
    lock_i |=> (!pe_req_i && !reject_i && rd_data_i == 24'h0));

  a_r5_lockout_keeps_bits: assert property (@(posedge clk_i) disable iff (!rst_ni)
    lock_i |=> $stable(prot_i));

  a_r4_trap_blocks_command: assert property (@(posedge clk_i) disable iff (!rst_ni)
    trap_i |=> (!pe_req_i && !reject_i));

  a_r7_bulk_protect_first: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pend_i |-> (&prot_i));

  a_r10_verify_shape: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_data_i[15:1] == 15'h0) && (rd_data_i[23:17] == 7'h0) && (rd_data_i[16] == rd_data_i[0]));
endmodule

bind flash_prot_ctrl flash_prot_chk #(.SECT_AW(SECT_AW)) u_chk (
  .clk_i    (clk_i),
  .rst_ni   (rst_ni),
  .lock_i   (lock_s),
  .hv_i     (hv_s),
  .trap_i   (trap_flag),
  .pend_i   (unp_pend),
  .prot_i   (prot_vec),
  .pe_req_i (pe_req_o),
  .reject_i (pe_reject_o),
  .sector_i (pe_sector_o),
  .rd_data_i(rd_data_o)
);

// File: tb/tb_flash_prot_ctrl.sv
module tb_flash_prot_ctrl;
  localparam int FILT = 4;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cs_n = 1'b1, oe_n = 1'b1, we_n = 1'b1;
  logic [11:0] addr = '0;
  logic [7:0]  data = '0;
  logic        vlow = 1'b0, hvrst = 1'b0;
  logic        pe_req, pe_rej, pe_erase;
  logic [2:0]  pe_sec;
  logic [23:0] rd_data;

  int checks = 0, fails = 0;
  int req_seen = 0, rej_seen = 0;
  logic [2:0] last_sec = '0;
  logic       last_erase = 1'b0;
  logic [7:0] prot_m = '0;  // reference protect bits
  bit         hv_m = 0;
  bit         done = 0;

  always #5 clk = ~clk;

  flash_prot_ctrl dut (
    .clk_i(clk), .rst_ni(rst_n), .cs_ni(cs_n), .oe_ni(oe_n), .we_ni(we_n),
    .addr_i(addr), .data_i(data), .vlow_i(vlow), .hvrst_i(hvrst),
    .pe_req_o(pe_req), .pe_reject_o(pe_rej), .pe_erase_o(pe_erase),
    .pe_sector_o(pe_sec), .rd_data_o(rd_data)
  );

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  // per-clock monitor, sampled after the edge
  always @(posedge clk) begin
    #2;
    if (rst_n) begin
      if (pe_req) begin req_seen++; last_sec = pe_sec; last_erase = pe_erase; end
      if (pe_rej) begin rej_seen++; last_sec = pe_sec; last_erase = pe_erase; end
      if (pe_req && pe_rej) chk(0, "R8 exclusive", 32'(pe_req), 32'(0));
    end
  end

  task automatic cycles(input int n);
    repeat (n) @(negedge clk);
  endtask

  // accept=0: bench expects the block to ignore the command entirely
  task automatic do_cmd(input logic [2:0] sec, input logic [7:0] code, input bit accept, input string req);
    bit is_pe, grant;
    is_pe = (code == 8'h10) || (code == 8'h30);
    grant = !prot_m[sec] || hv_m;
    @(negedge clk);
    addr = {sec, 9'h000}; data = code; cs_n = 1'b0; oe_n = 1'b1;
    cycles(2);
    we_n = 1'b0;
    cycles(8);
    req_seen = 0; rej_seen = 0;
    we_n = 1'b1;
    cycles(12);
    cs_n = 1'b1;
    cycles(3);
    if (accept && is_pe) begin
      chk(req_seen == (grant ? 1 : 0), req, req_seen, grant ? 1 : 0);
      chk(rej_seen == (grant ? 0 : 1), req, rej_seen, grant ? 0 : 1);
      chk(last_sec == sec && last_erase == (code == 8'h30), req,
          {last_erase, last_sec}, {(code == 8'h30), sec});
    end else begin
      chk(req_seen == 0 && rej_seen == 0, req, req_seen + rej_seen, 0);
    end
    if (accept && code == 8'h60) prot_m[sec] = 1'b1;
    if (accept && code == 8'h40) begin prot_m = 8'hFF; prot_m[sec] = 1'b0; end
  endtask

  task automatic verify(input logic [2:0] sec, input logic [8:0] low, input string req);
    logic [23:0] exp;
    bit hit;
    @(negedge clk);
    addr = {sec, low}; cs_n = 1'b0; oe_n = 1'b0; we_n = 1'b1;
    cycles(12);
    hit = !low[6] && low[1] && !low[0];
    exp = hit ? {7'b0, prot_m[sec], 8'h00, 7'b0, prot_m[sec]} : 24'h0;
    chk(rd_data == exp, req, rd_data, exp);
    oe_n = 1'b1; cs_n = 1'b1;
    cycles(3);
  endtask

  initial begin
    // power-up with a write already qualified (R4)
    cs_n = 1'b0; oe_n = 1'b1; we_n = 1'b0; addr = 12'h200; data = 8'h10;
    cycles(4);
    chk(pe_req == 0 && pe_rej == 0 && rd_data == 0, "R1 reset outputs", {pe_req, pe_rej}, 0);
    rst_n = 1'b1;
    cycles(30);
    req_seen = 0; rej_seen = 0;
    we_n = 1'b1;
    cycles(15);
    chk(req_seen == 0 && rej_seen == 0, "R4 power-up trap", req_seen, 0);
    cs_n = 1'b1;
    cycles(3);
    for (int s = 0; s < 8; s++) verify(3'(s), 9'h002, "R1 all unprotected");

    do_cmd(3'd0, 8'h10, 1, "R8 program grant");
    do_cmd(3'd6, 8'h30, 1, "R8 erase grant");

    // R2: output enable low during write
    @(negedge clk);
    addr = 12'h000; data = 8'h10; cs_n = 1'b0; oe_n = 1'b0; we_n = 1'b0;
    cycles(10); req_seen = 0; rej_seen = 0; we_n = 1'b1; cycles(12);
    chk(req_seen == 0 && rej_seen == 0, "R2 oe low inhibits", req_seen, 0);
    cs_n = 1'b1; oe_n = 1'b1; cycles(3);
    // R2: chip select high during write
    we_n = 1'b0; cycles(10); req_seen = 0; rej_seen = 0; we_n = 1'b1; cycles(12);
    chk(req_seen == 0 && rej_seen == 0, "R2 cs high inhibits", req_seen, 0);

    // R3: short write-enable pulse
    cs_n = 1'b0; cycles(8);
    req_seen = 0; rej_seen = 0;
    we_n = 1'b0; cycles(FILT - 1); we_n = 1'b1; cycles(15);
    chk(req_seen == 0 && rej_seen == 0, "R3 glitch rejected", req_seen, 0);
    cs_n = 1'b1; cycles(3);

    do_cmd(3'd3, 8'h60, 1, "R6 protect");
    verify(3'd3, 9'h002, "R6 protected reads 01");
    verify(3'd4, 9'h002, "R6 neighbour unchanged");
    do_cmd(3'd3, 8'h10, 1, "R8 program reject");
    do_cmd(3'd3, 8'h30, 1, "R8 erase reject");
    do_cmd(3'd3, 8'h55, 0, "R8 unknown byte ignored");

    hvrst = 1'b1; hv_m = 1; cycles(5);
    do_cmd(3'd3, 8'h10, 1, "R9 hv override grants");
    hvrst = 1'b0; hv_m = 0; cycles(5);
    do_cmd(3'd3, 8'h30, 1, "R9 reprotected after hv");
    verify(3'd3, 9'h002, "R9 bit retained");

    do_cmd(3'd5, 8'h40, 1, "R7 unprotect");
    for (int s = 0; s < 8; s++) verify(3'(s), 9'h002, "R7 bulk then clear");
    do_cmd(3'd5, 8'h10, 1, "R7 unprotected sector grants");
    do_cmd(3'd0, 8'h30, 1, "R7 others protected");

    verify(3'd3, 9'h003, "R10 bit0 high gives 0");
    verify(3'd3, 9'h042, "R10 bit6 high gives 0");
    verify(3'd3, 9'h000, "R10 bit1 low gives 0");

    vlow = 1'b1; cycles(5);
    do_cmd(3'd5, 8'h60, 0, "R5 protect ignored");
    do_cmd(3'd5, 8'h10, 0, "R5 program ignored");
    vlow = 1'b0; cycles(30);
    verify(3'd5, 9'h002, "R5 bits unchanged");
    do_cmd(3'd5, 8'h10, 1, "R5 accepted after lockout");

    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog: actual hung expected done");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end
endmodule